// File: doc/BRIEF.md
# Decorated-Address Bit-Manipulation Engine

This block sits on the path from a processor's data bus to a region of peripheral registers. A normal access reaches the peripheral unchanged. An access whose upper address bits carry an operation code becomes an atomic read-modify-write: the engine reads the target register, computes a result, and writes it back where the operation calls for a write. The processor needs only one bus transfer, and no other master can step in between the read and the write.

On the write side the operations are bitwise AND, OR and XOR with the write data, and a field insert. On the read side they are clear-one-bit and set-one-bit, which both return the original register contents, and an unsigned field extract. Each operation works at the byte, halfword or word size of the access. Data is aligned to the least significant bit. The peripheral applies a write only to the lanes that `p_size` names.

Top module: `bme_engine`

## Requirements
- R1: An access with c_addr[31:29]=3'b010, c_addr[28]=0 and c_addr[27:26]=0 is passed through in the same cycle. The peripheral sees p_addr = 0x4000_0000 | c_addr[19:0], the same direction, size and write data, and a read returns p_rdata.
- R2: A write with c_addr[28]=0 and c_addr[27:26] set to 1, 2 or 3 stores old AND, OR or XOR the write data. The register is selected by c_addr[19:0].
- R3: A write with c_addr[28]=1 is a field insert. The position b is c_addr[27:23], the width less one w is c_addr[22:19], and the register is selected by c_addr[18:0]. The stored value is (old & ~M) | (wdata & M), where M = ((1<<(w+1))-1)<<b.
- R4: A read with c_addr[28]=0 and c_addr[27:26]=2 clears bit c_addr[25:21], and with c_addr[27:26]=3 sets that bit. Both return the original register value.
- R5: A read with c_addr[28]=1 returns (old >> b) & ((1<<(w+1))-1), with b and w taken from the same bits as in R3. For example, 0x3A with b=1 and w=1 gives 0x1.
- R6: c_size 0, 1 and 2 select 8, 16 and 32 bits. The old value, the masks and the result are limited to that size. A bit or field that lies beyond the size changes nothing.
- R7: A decorated access holds c_ready low for exactly one cycle, the read phase. It completes in the next cycle, the write phase. Any write-back goes to the same p_addr that was read, and p_lock is high in both phases.
- R8: A field extract performs no write-back.
- R9: Three cases are answered in one cycle with c_err=1, c_rdata=0 and no peripheral access: an address with c_addr[31:29]≠3'b010, c_size=3, and a read with c_addr[28]=0 and c_addr[27:26]=1.
- R10: The decorated write operations return c_rdata=0.
- R11: After reset, and with no request pending, p_valid and p_lock are low and c_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| c_valid | input | 1 | Core request valid, held until c_ready |
| c_write | input | 1 | Core request is a write |
| c_addr | input | 32 | Core address, possibly decorated |
| c_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| c_wdata | input | 32 | Core write data, LSB-aligned |
| c_ready | output | 1 | Transfer completes this cycle |
| c_rdata | output | 32 | Read data returned to the core |
| c_err | output | 1 | Error response |
| p_valid | output | 1 | Peripheral access strobe |
| p_write | output | 1 | Peripheral access is a write |
| p_addr | output | 32 | Peripheral register address |
| p_size | output | 2 | Peripheral access size |
| p_wdata | output | 32 | Peripheral write data |
| p_rdata | input | 32 | Peripheral read data, valid in the same cycle |
| p_lock | output | 1 | Peripheral held for an atomic sequence |

## Verification
Each operation is tried on register values whose bits disagree with the operand in both directions. AND, OR and XOR therefore give three different results, and a swapped opcode shows up. The field insert and extract use a narrow field at a low position and a 16-bit field at position 16, which separates the width and position fields of the address. They also use the two extract examples 0x3A and 0x35, which catch an off-by-one in the width. Byte and halfword accesses with data above the access size, and a bit beyond the size, separate correct size masking from full-word operation. Counting peripheral strobes distinguishes a real write-back from a missing one, or from an access on the error path.

// File: rtl/bme_pkg.sv
package bme_pkg;

   localparam int FLD_FLAG_BIT = 28;
   localparam int CODE_HI      = 27;
   localparam int CODE_LO      = 26;
   localparam int POS_HI       = 27;
   localparam int POS_LO       = 23;
   localparam int WID_HI       = 22;
   localparam int WID_LO       = 19;
   localparam int BITNUM_HI    = 25;
   localparam int BITNUM_LO    = 21;
   localparam int LOGIC_OFS_W  = 20;
   localparam int FIELD_OFS_W  = 19;
   localparam int POS_W        = POS_HI - POS_LO + 1;
   localparam int WID_W        = WID_HI - WID_LO + 1;

   typedef enum logic [2:0] {
      OP_PLAIN, OP_AND, OP_OR, OP_XOR, OP_INS, OP_CLR, OP_SET, OP_EXT
   } bme_op_e;

   typedef struct packed {
      bme_op_e                  op;
      logic [POS_W-1:0]         pos;
      logic [WID_W-1:0]         wm1;
      logic [LOGIC_OFS_W-1:0]   ofs;
      logic                     err;
   } bme_dec_t;

endpackage

// File: rtl/bme_decode.sv
module bme_decode
   import bme_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter logic [2:0] REGION_TAG = 3'b010
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              write,
   input  logic [1:0]        size,
   output bme_dec_t          dec
);

   logic region_ok;
   assign region_ok = (addr[ADDR_W-1 -: 3] == REGION_TAG);

   always_comb begin
      dec = '0;
      if (addr[FLD_FLAG_BIT]) begin
         dec.op  = write ? OP_INS : OP_EXT;
         dec.pos = addr[POS_HI:POS_LO];
         dec.wm1 = addr[WID_HI:WID_LO];
         dec.ofs = LOGIC_OFS_W'(addr[FIELD_OFS_W-1:0]);
      end else begin
         dec.ofs = addr[LOGIC_OFS_W-1:0];
         dec.pos = addr[BITNUM_HI:BITNUM_LO];
         unique case (addr[CODE_HI:CODE_LO])
            2'd0: dec.op = OP_PLAIN;
            2'd1: begin
               dec.op  = OP_AND;
               dec.err = !write;
            end
            2'd2: dec.op = write ? OP_OR  : OP_CLR;
            default: dec.op = write ? OP_XOR : OP_SET;
         endcase
      end
      if (!region_ok || size == 2'b11) dec.err = 1'b1;
   end

endmodule

// File: rtl/bme_alu.sv
module bme_alu
   import bme_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  bme_op_e             op,
   input  logic [POS_W-1:0]    pos,
   input  logic [WID_W-1:0]    wm1,
   input  logic [1:0]          size,
   input  logic [DATA_W-1:0]   old_val,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   new_val,
   output logic [DATA_W-1:0]   ret_val,
   output logic                need_wb
);

   localparam int SHW = $clog2(DATA_W) + 1;
   localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

   logic [DATA_W-1:0] size_mask [4];

   for (genvar k = 0; k < 4; k++) begin : g_size
      localparam int LANE_W = 8 << k;
      if (LANE_W >= DATA_W) begin : g_full
         assign size_mask[k] = ONES;
      end else begin : g_part
         assign size_mask[k] = ONES >> (DATA_W - LANE_W);
      end
   end

   logic [DATA_W-1:0] smask, old_m, wd_m, fld_lo, fmask, bit1;
   logic [SHW-1:0]    shamt;

   always_comb begin
      smask  = size_mask[size];
      old_m  = old_val & smask;
      wd_m   = wdata & smask;
      shamt  = SHW'(DATA_W - 1) - SHW'(wm1);
      fld_lo = ONES >> shamt;
      fmask  = (fld_lo << pos) & smask;
      bit1   = (DATA_W'(1) << pos) & smask;
   end

   always_comb begin
      new_val = old_m;
      ret_val = '0;
      need_wb = 1'b1;
      unique case (op)
         OP_AND: new_val = old_m & wd_m;
         OP_OR:  new_val = old_m | wd_m;
         OP_XOR: new_val = old_m ^ wd_m;
         OP_INS: new_val = (old_m & ~fmask) | (wd_m & fmask);
         OP_CLR: begin
            new_val = old_m & ~bit1;
            ret_val = old_m;
         end
         OP_SET: begin
            new_val = old_m | bit1;
            ret_val = old_m;
         end
         OP_EXT: begin
            ret_val = (old_m >> pos) & fld_lo;
            need_wb = 1'b0;
         end
         default: need_wb = 1'b0;
      endcase
   end

endmodule

// File: rtl/bme_engine.sv
module bme_engine
   import bme_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter int          DATA_W      = 32,
   parameter logic [31:0] REGION_BASE = 32'h4000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              c_valid,
   input  logic              c_write,
   input  logic [ADDR_W-1:0] c_addr,
   input  logic [1:0]        c_size,
   input  logic [DATA_W-1:0] c_wdata,
   output logic              c_ready,
   output logic [DATA_W-1:0] c_rdata,
   output logic              c_err,
   output logic              p_valid,
   output logic              p_write,
   output logic [ADDR_W-1:0] p_addr,
   output logic [1:0]        p_size,
   output logic [DATA_W-1:0] p_wdata,
   input  logic [DATA_W-1:0] p_rdata,
   output logic              p_lock
);

   if (DATA_W != 32) begin : g_bad_data
      $error("bme_engine: bit and width fields need DATA_W of 32");
   end
   if (ADDR_W != 32) begin : g_bad_addr
      $error("bme_engine: decoration layout needs ADDR_W of 32");
   end
   if (REGION_BASE[LOGIC_OFS_W-1:0] != '0) begin : g_bad_base
      $error("bme_engine: REGION_BASE must be aligned to the offset span");
   end

   localparam logic [2:0] REGION_TAG = REGION_BASE[31:29];

   typedef enum logic {ST_IDLE, ST_WB} st_e;

   st_e               st;
   bme_dec_t          dec;
   logic              is_decor, start;
   logic [ADDR_W-1:0] paddr_now;

   bme_op_e           h_op;
   logic [POS_W-1:0]  h_pos;
   logic [WID_W-1:0]  h_wm1;
   logic [1:0]        h_size;
   logic [DATA_W-1:0] h_wdata, h_old;
   logic [ADDR_W-1:0] h_paddr;

   logic [DATA_W-1:0] alu_new, alu_ret;
   logic              alu_wb;

   bme_decode #(
      .ADDR_W     (ADDR_W),
      .REGION_TAG (REGION_TAG)
   ) u_dec (
      .addr  (c_addr),
      .write (c_write),
      .size  (c_size),
      .dec   (dec)
   );

   assign is_decor  = (dec.op != OP_PLAIN) && !dec.err;
   assign start     = (st == ST_IDLE) && c_valid && is_decor;
   assign paddr_now = REGION_BASE | ADDR_W'(dec.ofs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         h_op    <= OP_PLAIN;
         h_pos   <= '0;
         h_wm1   <= '0;
         h_size  <= '0;
         h_wdata <= '0;
         h_old   <= '0;
         h_paddr <= '0;
      end else if (start) begin
         st      <= ST_WB;
         h_op    <= dec.op;
         h_pos   <= dec.pos;
         h_wm1   <= dec.wm1;
         h_size  <= c_size;
         h_wdata <= c_wdata;
         h_old   <= p_rdata;
         h_paddr <= paddr_now;
      end else if (st == ST_WB) begin
         st <= ST_IDLE;
      end
   end

   bme_alu #(
      .DATA_W (DATA_W)
   ) u_alu (
      .op      (h_op),
      .pos     (h_pos),
      .wm1     (h_wm1),
      .size    (h_size),
      .old_val (h_old),
      .wdata   (h_wdata),
      .new_val (alu_new),
      .ret_val (alu_ret),
      .need_wb (alu_wb)
   );

   always_comb begin
      c_ready = 1'b1;
      c_rdata = '0;
      c_err   = 1'b0;
      p_valid = 1'b0;
      p_write = 1'b0;
      p_addr  = paddr_now;
      p_size  = c_size;
      p_wdata = c_wdata;
      p_lock  = 1'b0;
      if (st == ST_WB) begin
         c_rdata = alu_ret;
         p_lock  = 1'b1;
         p_addr  = h_paddr;
         p_size  = h_size;
         p_wdata = alu_new;
         p_valid = alu_wb;
         p_write = alu_wb;
      end else if (c_valid) begin
         if (dec.err) begin
            c_err = 1'b1;
         end else if (!is_decor) begin
            p_valid = 1'b1;
            p_write = c_write;
            c_rdata = c_write ? '0 : p_rdata;
         end else begin
            c_ready = 1'b0;
            p_valid = 1'b1;
            p_lock  = 1'b1;
         end
      end
   end

endmodule

// File: rtl/bme_engine_chk.sv
module bme_engine_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              c_valid,
   input logic              c_write,
   input logic              c_ready,
   input logic              c_err,
   input logic [DATA_W-1:0] c_rdata,
   input logic              p_valid,
   input logic              p_write,
   input logic              p_lock,
   input logic [ADDR_W-1:0] p_addr
);

   AST_READ_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      c_valid && !c_ready |-> p_valid && !p_write && p_lock);  // R7

   AST_ONE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      c_valid && !c_ready |=> c_ready && p_lock);  // R7

   AST_SAME_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(c_valid && !c_ready) && p_valid |-> p_write && p_addr == $past(p_addr));  // R7

   AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      c_err |-> c_ready && !p_valid && !p_lock);  // R9

   AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      c_err |-> c_rdata == '0);  // R9

   AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      c_valid && c_write && c_ready |-> c_rdata == '0);  // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !c_valid && !$past(c_valid && !c_ready) |-> !p_valid && !p_lock && c_ready);  // R11

endmodule

bind bme_engine bme_engine_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .c_valid (c_valid),
   .c_write (c_write),
   .c_ready (c_ready),
   .c_err   (c_err),
   .c_rdata (c_rdata),
   .p_valid (p_valid),
   .p_write (p_write),
   .p_lock  (p_lock),
   .p_addr  (p_addr)
);

// File: tb/bme_engine_tb_top.sv
`timescale 1ns/1ps
module bme_engine_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        c_valid = 1'b0;
   logic        c_write = 1'b0;
   logic [31:0] c_addr = '0;
   logic [1:0]  c_size = '0;
   logic [31:0] c_wdata = '0;
   logic        c_ready, c_err;
   logic [31:0] c_rdata;
   logic        p_valid, p_write, p_lock;
   logic [31:0] p_addr, p_wdata, p_rdata;
   logic [1:0]  p_size;

   int checks = 0;
   int errors = 0;
   int acc_cnt = 0;
   logic [31:0] regs [8];

   always #4 clk = ~clk;

   bme_engine dut_i (
      .clk(clk), .rst_n(rst_n),
      .c_valid(c_valid), .c_write(c_write), .c_addr(c_addr), .c_size(c_size),
      .c_wdata(c_wdata), .c_ready(c_ready), .c_rdata(c_rdata), .c_err(c_err),
      .p_valid(p_valid), .p_write(p_write), .p_addr(p_addr), .p_size(p_size),
      .p_wdata(p_wdata), .p_rdata(p_rdata), .p_lock(p_lock)
   );

   // peripheral model: eight word registers at 0x4000_0000 + 4*i
   assign p_rdata = regs[p_addr[4:2]];

   always @(posedge clk) begin
      if (p_valid) begin
         acc_cnt <= acc_cnt + 1;
         if (p_write) begin
            case (p_size)
               2'd0:    regs[p_addr[4:2]][7:0]  <= p_wdata[7:0];
               2'd1:    regs[p_addr[4:2]][15:0] <= p_wdata[15:0];
               default: regs[p_addr[4:2]]       <= p_wdata;
            endcase
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic xfer(input logic w, input logic [31:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd,
                       output logic er, output int cyc, output int acc);
      int acc0;
      logic done;
      @(negedge clk);
      acc0 = acc_cnt;
      c_valid = 1'b1; c_write = w; c_addr = a; c_size = sz; c_wdata = wd;
      cyc = 0;
      done = 1'b0;
      while (!done && cyc < 10) begin
         #2;
         cyc++;
         rd = c_rdata; er = c_err; done = c_ready;
         @(negedge clk);
      end
      c_valid = 1'b0; c_write = 1'b0;
      acc = acc_cnt - acc0;
   endtask

   function automatic logic [31:0] fld(input logic [31:0] base, input int b, input int w, input int ofs);
      return base | (32'(b) << 23) | (32'(w) << 19) | 32'(ofs);
   endfunction

   task automatic t_reset();
      #2;
      check("R11 p_valid after reset", {31'b0, p_valid}, 32'd0);
      check("R11 p_lock after reset", {31'b0, p_lock}, 32'd0);
      check("R11 c_ready after reset", {31'b0, c_ready}, 32'd1);
   endtask

   task automatic t_plain();
      logic [31:0] rd; logic er; int cyc, acc;
      xfer(1'b1, 32'h4000_0004, 2'd2, 32'hDEAD_BEEF, rd, er, cyc, acc);
      check("R1 plain write cycles", 32'(cyc), 32'd1);
      check("R1 plain write accesses", 32'(acc), 32'd1);
      check("R1 plain write stored", regs[1], 32'hDEAD_BEEF);
      regs[2] = 32'h0BAD_F00D;
      xfer(1'b0, 32'h4000_0008, 2'd2, 32'h0, rd, er, cyc, acc);
      check("R1 plain read data", rd, 32'h0BAD_F00D);
      check("R1 plain read cycles", 32'(cyc), 32'd1);
   endtask

   task automatic t_logic();
      logic [31:0] rd; logic er; int cyc, acc;
      regs[2] = 32'hFFFF_00F0;
      xfer(1'b1, 32'h4400_0008, 2'd2, 32'h0F0F_0F3C, rd, er, cyc, acc);
      check("R2 AND result", regs[2], 32'h0F0F_0030);
      check("R7 AND cycles", 32'(cyc), 32'd2);
      check("R7 AND read+write accesses", 32'(acc), 32'd2);
      check("R10 AND returns zero", rd, 32'h0);
      regs[3] = 32'h1234_0000;
      xfer(1'b1, 32'h4800_000C, 2'd2, 32'h0000_00FF, rd, er, cyc, acc);
      check("R2 OR result", regs[3], 32'h1234_00FF);
      regs[4] = 32'hAAAA_5555;
      xfer(1'b1, 32'h4C00_0010, 2'd2, 32'hFFFF_0000, rd, er, cyc, acc);
      check("R2 XOR result", regs[4], 32'h5555_5555);
      check("R10 XOR returns zero", rd, 32'h0);
   endtask

   task automatic t_insert();
      logic [31:0] rd; logic er; int cyc, acc;
      regs[5] = 32'h0000_00A3;
      xfer(1'b1, fld(32'h5000_0000, 5, 1, 32'h14), 2'd2, 32'h0000_0040, rd, er, cyc, acc);
      check("R3 insert narrow field", regs[5], 32'h0000_00C3);
      check("R7 insert cycles", 32'(cyc), 32'd2);
      regs[6] = 32'h1234_5678;
      xfer(1'b1, fld(32'h5000_0000, 16, 15, 32'h18), 2'd2, 32'hABCD_9999, rd, er, cyc, acc);
      check("R3 insert 16-bit field", regs[6], 32'hABCD_5678);
   endtask

   task automatic t_clrset();
      logic [31:0] rd; logic er; int cyc, acc;
      regs[7] = 32'h0000_0107;
      xfer(1'b0, 32'h4800_001C | (32'd1 << 21), 2'd2, 32'h0, rd, er, cyc, acc);
      check("R4 clear-bit result", regs[7], 32'h0000_0105);
      check("R4 clear-bit returns old", rd, 32'h0000_0107);
      check("R7 clear-bit accesses", 32'(acc), 32'd2);
      regs[0] = 32'h8000_0000;
      xfer(1'b0, 32'h4C00_0000 | (32'd4 << 21), 2'd2, 32'h0, rd, er, cyc, acc);
      check("R4 set-bit result", regs[0], 32'h8000_0010);
      check("R4 set-bit returns old", rd, 32'h8000_0000);
   endtask

   task automatic t_extract();
      logic [31:0] rd; logic er; int cyc, acc;
      regs[1] = 32'h0000_003A;
      xfer(1'b0, fld(32'h5000_0000, 1, 1, 32'h04), 2'd2, 32'h0, rd, er, cyc, acc);
      check("R5 extract from 0x3A", rd, 32'h1);
      check("R8 extract single access", 32'(acc), 32'd1);
      check("R8 extract leaves register", regs[1], 32'h0000_003A);
      regs[1] = 32'h0000_0035;
      xfer(1'b0, fld(32'h5000_0000, 1, 1, 32'h04), 2'd2, 32'h0, rd, er, cyc, acc);
      check("R5 extract from 0x35", rd, 32'h2);
      regs[3] = 32'hF00D_CAFE;
      xfer(1'b0, fld(32'h5000_0000, 16, 15, 32'h0C), 2'd2, 32'h0, rd, er, cyc, acc);
      check("R5 extract upper half", rd, 32'h0000_F00D);
   endtask

   task automatic t_size();
      logic [31:0] rd; logic er; int cyc, acc;
      regs[2] = 32'h1234_56F0;
      xfer(1'b1, 32'h4800_0008, 2'd0, 32'hFFFF_FF0F, rd, er, cyc, acc);
      check("R6 byte OR", regs[2], 32'h1234_56FF);
      regs[3] = 32'h00AB_1234;
      xfer(1'b0, 32'h4C00_000C | (32'd20 << 21), 2'd1, 32'h0, rd, er, cyc, acc);
      check("R6 halfword set beyond size unchanged", regs[3], 32'h00AB_1234);
      check("R6 halfword set returns masked old", rd, 32'h0000_1234);
      regs[4] = 32'hFFFF_FF35;
      xfer(1'b0, fld(32'h5000_0000, 4, 7, 32'h10), 2'd0, 32'h0, rd, er, cyc, acc);
      check("R6 byte extract", rd, 32'h0000_0003);
   endtask

   task automatic t_error();
      logic [31:0] rd; logic er; int cyc, acc;
      xfer(1'b0, 32'h4400_0008, 2'd2, 32'h0, rd, er, cyc, acc);
      check("R9 read with AND code err", {31'b0, er}, 32'd1);
      check("R9 read with AND code no access", 32'(acc), 32'd0);
      check("R9 read with AND code data", rd, 32'h0);
      xfer(1'b1, 32'h6000_0008, 2'd2, 32'h1, rd, er, cyc, acc);
      check("R9 outside region err", {31'b0, er}, 32'd1);
      check("R9 outside region cycles", 32'(cyc), 32'd1);
      regs[2] = 32'h5A5A_5A5A;
      xfer(1'b1, 32'h4000_0008, 2'd3, 32'h0, rd, er, cyc, acc);
      check("R9 size 3 err", {31'b0, er}, 32'd1);
      check("R9 size 3 register untouched", regs[2], 32'h5A5A_5A5A);
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) regs[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_logic();
      t_insert();
      t_clrset();
      t_extract();
      t_size();
      t_error();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule